// File: doc/BRIEF.md
# Prescaled Capture/Compare Timer Channel

This block is one 16-bit timer channel. Its counter advances on a count tick that comes from one of nine internal divided versions of the block clock or from the rising edge of one of four external clock pins. Any source can be switched off to freeze the counter. One compare register and one capture register work against the counter. A compare match can raise a flag, toggle an output pin and clear the counter. A rising edge on the capture pin stores the counter value, raises a flag and can also clear the counter.

All pins pass through a two-flop synchronizer and a majority-free stability filter. A filter output changes only after its input has held a new level for three block clocks in a row. In buffered mode, software writes to the compare address land in a buffer register. The active compare value takes the buffer only on a cycle when the counter is cleared or wraps, so a period or duty change never produces a partial cycle. Software reaches the block through a single-cycle write port and a combinational read port, each with a 3-bit address. The three event flags drive the interrupt outputs directly.

Top module: `tmr_channel`

## Requirements
- R1: A source select of 0 to 8 in control bits [3:0] advances the counter once every 1, 2, 4, 8, 16, 32, 64, 256 and 1024 clocks respectively. Over any K·N consecutive clocks with divide N, the counter advances by exactly K.
- R2: Source selects 9 to 12 count filtered rising edges of external pin 0 to 3, and activity on the other pins has no effect. Selects 13 to 15 stop the counter. Writing address 1 loads the counter.
- R3: A tick while the counter holds 0xFFFF wraps it to 0 and sets the overflow flag (status bit 2).
- R4: A tick while the counter equals the compare register sets the match flag (status bit 0). With clear source 1 (control bits [5:4]), the counter goes to 0 instead of incrementing. With clear source 0, counting goes on past the compare value.
- R5: When toggle mode (control bit 6) is set, cmp_o inverts on every match. When toggle mode is clear, cmp_o holds its level.
- R6: A filtered rising edge on cap_i copies the counter into the capture register (address 4) and sets the capture flag (status bit 1). With clear source 2, it also clears the counter.
- R7: A pin pulse that is shorter than three clocks after synchronization is ignored, on both cap_i and the external clock pins.
- R8: With buffered mode set (control bit 7), writes to address 2 go only to the buffer (address 3). The active compare (address 2) takes the buffer value on the cycle of a counter clear or wrap. With buffered mode clear, a write to address 2 updates both the compare register and the buffer at once.
- R9: Writing the status register (address 5) clears each flag whose data bit is 1 and leaves the flags whose bit is 0. A flag that is set in the same cycle stays set.
- R10: After reset: control reads 0x000F (stopped), counter 0, compare 0xFFFF, buffer 0xFFFF, capture 0, status 0, and cmp_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per clock |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Read data for rd_addr (combinational) |
| ext_clk_i | input | 4 | External count clock pins |
| cap_i | input | 1 | Capture trigger pin |
| cmp_o | output | 1 | Compare output pin |
| irq_match_o | output | 1 | Match flag |
| irq_cap_o | output | 1 | Capture flag |
| irq_ovf_o | output | 1 | Overflow flag |

## Verification
The assertions assume that the pins are held low through reset and that software never writes reserved clear-source code 3. They also assume that a counter write takes priority over the match-clear and wrap checks, so those properties are switched off during such a write. The stimulus keeps to these limits. It changes the control register only through the write port and drives pin pulses at least three clocks wide whenever a pulse is meant to count. It uses two-clock pulses only where a pulse is meant to be rejected. It also reprograms counter, compare and buffer values only while the source is stopped, except in the buffered tests, which load the buffer on purpose while the counter is running.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int NUM_TAPS = 9;
    localparam int FLAG_W   = 3;
    localparam int F_MATCH  = 0;
    localparam int F_CAP    = 1;
    localparam int F_OVF    = 2;

    typedef enum logic [1:0] {
        CLR_NONE  = 2'd0,
        CLR_MATCH = 2'd1,
        CLR_CAPT  = 2'd2,
        CLR_RSVD  = 2'd3
    } clr_src_e;

    typedef enum logic [2:0] {
        A_CTRL  = 3'd0,
        A_COUNT = 3'd1,
        A_CMP   = 3'd2,
        A_BUF   = 3'd3,
        A_CAPT  = 3'd4,
        A_STAT  = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic       buffered;
        logic       toggle;
        clr_src_e   clr;
        logic [3:0] src;
    } ctrl_t;

    // log2 of each internal divide ratio; the set deliberately skips 7 and 9
    function automatic int tap_exp(input int idx);
        case (idx)
            7:       return 8;
            8:       return 10;
            default: return idx;
        endcase
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int TAPS = NUM_TAPS
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TAPS-1:0] tick_o
);

    localparam int PRE_W = tap_exp(TAPS-1);

    logic [PRE_W-1:0] pre_d, pre_q;

    always_comb begin
        pre_d = pre_q + PRE_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // Each tap fires once every 2^E clocks, when the low E bits are all ones
    for (genvar t = 0; t < TAPS; t++) begin : g_tap
        localparam int E = tap_exp(t);
        if (E == 0) begin : g_every
            assign tick_o[t] = 1'b1;
        end else begin : g_masked
            assign tick_o[t] = &pre_q[E-1:0];
        end
        if (t > 0) begin : g_chk
            // a coarser tap can only fire when every finer tap fires too
            p_tap_nest_r1 : assert property (@(posedge clk) disable iff (!rst_n)
                tick_o[t] |-> tick_o[t-1]);
        end
    end

endmodule

// File: rtl/tmr_pin_filter.sv
module tmr_pin_filter #(
    parameter int W     = 1,
    parameter int DEPTH = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] rise_o
);

    typedef struct packed {
        logic [W-1:0]            s1;
        logic [W-1:0]            s2;
        logic [DEPTH-1:0][W-1:0] hist;
        logic [W-1:0]            lvl;
        logic [W-1:0]            prev;
    } filt_t;

    filt_t d, q;

    always_comb begin
        logic all_hi;
        logic all_lo;
        d      = q;
        d.s1   = pin_i;
        d.s2   = q.s1;
        d.hist = {q.hist[DEPTH-2:0], q.s2};
        d.prev = q.lvl;
        for (int b = 0; b < W; b++) begin
            all_hi = 1'b1;
            all_lo = 1'b1;
            for (int k = 0; k < DEPTH; k++) begin
                all_hi = all_hi & q.hist[k][b];
                all_lo = all_lo & ~q.hist[k][b];
            end
            if (all_hi)      d.lvl[b] = 1'b1;
            else if (all_lo) d.lvl[b] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rise_o = q.lvl & ~q.prev;

    for (genvar b = 0; b < W; b++) begin : g_chk
        // a filtered level only moves to the value the oldest sample held
        p_lvl_agree_r7 : assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(q.lvl[b]) |-> (q.lvl[b] == $past(q.hist[DEPTH-1][b])));
    end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int N_EXT      = 4,
    parameter int FILT_DEPTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [2:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    input  logic [N_EXT-1:0] ext_clk_i,
    input  logic             cap_i,
    output logic             cmp_o,
    output logic             irq_match_o,
    output logic             irq_cap_o,
    output logic             irq_ovf_o
);

    localparam int SRC_EXT0 = NUM_TAPS;
    localparam int CTRL_W   = $bits(ctrl_t);

    typedef struct packed {
        ctrl_t             ctrl;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  cmp;
        logic [CNT_W-1:0]  bufr;
        logic [CNT_W-1:0]  cap;
        logic [FLAG_W-1:0] flags;
        logic              cmp_o;
    } chan_t;

    chan_t d, q;

    logic [NUM_TAPS-1:0] tap_tick;
    logic [N_EXT-1:0]    ext_rise;
    logic                cap_rise;

    tmr_prescaler #(.TAPS(NUM_TAPS)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tap_tick)
    );

    tmr_pin_filter #(.W(N_EXT), .DEPTH(FILT_DEPTH)) u_ext_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_clk_i),
        .rise_o (ext_rise)
    );

    tmr_pin_filter #(.W(1), .DEPTH(FILT_DEPTH)) u_cap_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (cap_i),
        .rise_o (cap_rise)
    );

    logic tick, match_evt, ovf_evt, clr_evt, xfer, cnt_wr;

    always_comb begin
        tick = 1'b0;
        for (int i = 0; i < NUM_TAPS; i++) begin
            if (q.ctrl.src == 4'(i)) tick = tap_tick[i];
        end
        for (int j = 0; j < N_EXT; j++) begin
            if (q.ctrl.src == 4'(SRC_EXT0 + j)) tick = ext_rise[j];
        end
    end

    assign match_evt = tick && (q.cnt == q.cmp);
    assign ovf_evt   = tick && (q.cnt == '1);
    assign clr_evt   = ((q.ctrl.clr == CLR_MATCH) && match_evt) ||
                       ((q.ctrl.clr == CLR_CAPT)  && cap_rise);
    assign xfer      = q.ctrl.buffered && (clr_evt || ovf_evt);
    assign cnt_wr    = wr_en && (wr_addr == A_COUNT);

    always_comb begin
        logic [FLAG_W-1:0] set_m;
        logic [FLAG_W-1:0] clr_m;
        d = q;

        // counting and clearing
        if (clr_evt)   d.cnt = '0;
        else if (tick) d.cnt = q.cnt + CNT_W'(1);

        // buffered compare transfer at a safe point
        if (xfer) d.cmp = q.bufr;

        // capture and compare output
        if (cap_rise) d.cap = q.cnt;
        if (match_evt && q.ctrl.toggle) d.cmp_o = ~q.cmp_o;

        // software access
        clr_m = '0;
        if (wr_en) begin
            case (wr_addr)
                A_CTRL:  d.ctrl = ctrl_t'(wr_data[CTRL_W-1:0]);
                A_COUNT: d.cnt  = wr_data;
                A_CMP: begin
                    d.bufr = wr_data;
                    if (!q.ctrl.buffered) d.cmp = wr_data;
                end
                A_STAT:  clr_m = wr_data[FLAG_W-1:0];
                default: ;
            endcase
        end

        // flags: writing 1 clears, a new event in the same cycle wins
        set_m          = '0;
        set_m[F_MATCH] = match_evt;
        set_m[F_CAP]   = cap_rise;
        set_m[F_OVF]   = ovf_evt;
        d.flags        = (q.flags & ~clr_m) | set_m;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.ctrl.src <= 4'hF;
            q.cmp      <= '1;
            q.bufr     <= '1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (rd_addr)
            A_CTRL:  rd_data = {{(CNT_W-CTRL_W){1'b0}}, q.ctrl};
            A_COUNT: rd_data = q.cnt;
            A_CMP:   rd_data = q.cmp;
            A_BUF:   rd_data = q.bufr;
            A_CAPT:  rd_data = q.cap;
            A_STAT:  rd_data = {{(CNT_W-FLAG_W){1'b0}}, q.flags};
            default: rd_data = '0;
        endcase
    end

    assign cmp_o       = q.cmp_o;
    assign irq_match_o = q.flags[F_MATCH];
    assign irq_cap_o   = q.flags[F_CAP];
    assign irq_ovf_o   = q.flags[F_OVF];

    // without a tick, a clear or a software load the counter stays put
    p_cnt_hold_r1 : assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr_evt && !cnt_wr) |=> (q.cnt == $past(q.cnt)));

    p_ovf_flag_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (q.cnt == '1)) |=> irq_ovf_o);

    p_clr_match_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        (match_evt && (q.ctrl.clr == CLR_MATCH) && !cnt_wr) |=> (q.cnt == '0));

    p_toggle_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        (match_evt && q.ctrl.toggle) |=> (cmp_o != $past(cmp_o)));

    p_cap_latch_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        cap_rise |=> ((q.cap == $past(q.cnt)) && irq_cap_o));

    p_buf_hold_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        (q.ctrl.buffered && !clr_evt && !ovf_evt) |=> $stable(q.cmp));

endmodule

// File: tb/tmr_channel_test.sv
module tmr_channel_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [3:0]  ext_clk_i = '0;
    logic        cap_i = 1'b0;
    logic        cmp_o, irq_match_o, irq_cap_o, irq_ovf_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    tmr_channel uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ext_clk_i(ext_clk_i), .cap_i(cap_i),
        .cmp_o(cmp_o), .irq_match_o(irq_match_o), .irq_cap_o(irq_cap_o), .irq_ovf_o(irq_ovf_o)
    );

    function automatic int tap_div(input int s);
        case (s)
            0: return 1;    1: return 2;   2: return 4;   3: return 8;
            4: return 16;   5: return 32;  6: return 64;  7: return 256;
            default: return 1024;
        endcase
    endfunction

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic check_true(input string req, input bit cond, input int got);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s: got 0x%0h, expected condition to hold", req, got);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_pins(input logic [3:0] m, input int n, input int hi, input int lo);
        for (int k = 0; k < n; k++) begin
            ext_clk_i = m;  wait_clk(hi);
            ext_clk_i = '0; wait_clk(lo);
        end
    endtask

    task automatic pulse_cap(input int hi);
        @(negedge clk);
        cap_i = 1'b1; wait_clk(hi);
        cap_i = 1'b0; wait_clk(12);
    endtask

    task automatic tap_trial(input int s, input int k);
        int c1, c2;
        wr(3'd0, 16'(s));
        wait_clk(3);
        rd(3'd1, c1);
        wait_clk(k * tap_div(s));
        rd(3'd1, c2);
        check($sformatf("R1 tap %0d K=%0d", s, k), (c2 - c1) & 16'hFFFF, k);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        int v, v2, cnt_max, toggles;
        logic prev;
        void'($urandom(32'd5150));
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);

        // R10 reset state
        rd(3'd0, v); check("R10 ctrl", v, 16'h000F);
        rd(3'd1, v); check("R10 count", v, 0);
        rd(3'd2, v); check("R10 compare", v, 16'hFFFF);
        rd(3'd3, v); check("R10 buffer", v, 16'hFFFF);
        rd(3'd4, v); check("R10 capture", v, 0);
        rd(3'd5, v); check("R10 status", v, 0);
        check("R10 cmp_o", int'(cmp_o), 0);

        // R2 load and stop
        wr(3'd1, 16'h1234);
        pulse_pins(4'hF, 3, 4, 4);
        rd(3'd1, v); check("R2 stopped count holds", v, 16'h1234);

        // R1 every tap, then random taps
        for (int s = 0; s < 9; s++) tap_trial(s, 3);
        for (int t = 0; t < 12; t++) tap_trial(int'($urandom % 9), 1 + int'($urandom % 3));

        // R2/R7 external pins
        for (int p = 0; p < 4; p++) begin
            logic [3:0] sel_m, oth_m;
            sel_m = 4'b1 << p;
            oth_m = 4'b1 << ((p + 1) % 4);
            wr(3'd0, 16'h000F);
            wr(3'd1, 16'h0000);
            wr(3'd0, 16'(9 + p));
            pulse_pins(sel_m | oth_m, 5, 4, 4);
            pulse_pins(oth_m, 3, 4, 4);
            wait_clk(10);
            rd(3'd1, v); check($sformatf("R2 ext pin %0d edges", p), v, 5);
            pulse_pins(sel_m, 3, 2, 5);
            wait_clk(10);
            rd(3'd1, v); check($sformatf("R7 ext pin %0d glitch", p), v, 5);
        end
        wr(3'd0, 16'h000D);
        pulse_pins(4'hF, 4, 4, 4);
        wait_clk(10);
        rd(3'd1, v); check("R2 select 13 stopped", v, 5);

        // R6 capture, directed then random
        wr(3'd0, 16'h000F);
        wr(3'd5, 16'h0007);
        wr(3'd1, 16'h0ABC);
        pulse_cap(6);
        rd(3'd4, v); check("R6 capture value", v, 16'h0ABC);
        rd(3'd5, v); check("R6 capture flag", v, 16'h0002);
        check("R6 irq_cap_o", int'(irq_cap_o), 1);
        rd(3'd1, v); check("R6 no clear with source 0", v, 16'h0ABC);
        for (int t = 0; t < 6; t++) begin
            v2 = int'($urandom & 16'hFFFF);
            wr(3'd1, 16'(v2));
            pulse_cap(3 + int'($urandom % 4));
            rd(3'd4, v); check("R6 random capture", v, v2);
        end
        // R7 short pulse on capture is ignored
        wr(3'd5, 16'h0007);
        wr(3'd1, 16'h0321);
        pulse_cap(2);
        rd(3'd5, v); check("R7 capture glitch flag", v, 0);
        rd(3'd4, v); check("R7 capture glitch value", v, v2);
        // R6 clear on capture
        wr(3'd0, 16'h002F);
        wr(3'd1, 16'h0555);
        pulse_cap(6);
        rd(3'd4, v); check("R6 clear-on-capture value", v, 16'h0555);
        rd(3'd1, v); check("R6 clear-on-capture count", v, 0);

        // R4/R5 match, clear and toggle
        wr(3'd0, 16'h000F);
        wr(3'd2, 16'h0009);
        wr(3'd1, 16'h0000);
        wr(3'd5, 16'h0007);
        wr(3'd0, 16'h0050);
        wait_clk(20);
        rd_addr = 3'd1;
        cnt_max = 0; toggles = 0; prev = cmp_o;
        for (int t = 0; t < 100; t++) begin
            @(negedge clk);
            if (int'(rd_data) > cnt_max) cnt_max = int'(rd_data);
            if (cmp_o != prev) toggles++;
            prev = cmp_o;
        end
        check_true("R4 count bounded by compare", cnt_max == 9, cnt_max);
        check("R5 toggles in 100 clocks", toggles, 10);
        check("R4 match flag", int'(irq_match_o), 1);
        wr(3'd0, 16'h0010);
        prev = cmp_o; toggles = 0;
        for (int t = 0; t < 50; t++) begin
            @(negedge clk);
            if (cmp_o != prev) toggles++;
            prev = cmp_o;
        end
        check("R5 no toggle when mode off", toggles, 0);
        wr(3'd0, 16'h0000);
        wait_clk(30);
        rd(3'd1, v); check_true("R4 no clear with source 0", v > 9, v);

        // R3 overflow and R9 W1C
        wr(3'd0, 16'h000F);
        wr(3'd1, 16'hFFF0);
        wr(3'd5, 16'h0007);
        wr(3'd0, 16'h0000);
        wait_clk(30);
        wr(3'd0, 16'h000F);
        rd(3'd1, v); check_true("R3 wrapped count", v > 0 && v < 16'h40, v);
        rd(3'd5, v); check("R3 overflow and match flags", v, 16'h0005);
        wr(3'd5, 16'h0001);
        rd(3'd5, v); check("R9 clear match only", v, 16'h0004);
        wr(3'd5, 16'h0000);
        rd(3'd5, v); check("R9 write zero keeps", v, 16'h0004);

        // R8 buffered compare
        wr(3'd0, 16'h008F);
        wr(3'd2, 16'h0100);
        rd(3'd2, v); check("R8 compare held", v, 16'h0009);
        rd(3'd3, v); check("R8 buffer loaded", v, 16'h0100);
        wr(3'd1, 16'hFFF8);
        wr(3'd0, 16'h0080);
        wait_clk(20);
        wr(3'd0, 16'h008F);
        rd(3'd2, v); check("R8 transfer on wrap", v, 16'h0100);
        wr(3'd0, 16'h000F);
        wr(3'd2, 16'h0200);
        rd(3'd2, v); check("R8 direct compare", v, 16'h0200);
        rd(3'd3, v); check("R8 direct buffer", v, 16'h0200);
        wr(3'd0, 16'h009F);
        wr(3'd2, 16'h0007);
        rd(3'd2, v); check("R8 compare held before clear", v, 16'h0200);
        wr(3'd1, 16'h01F0);
        wr(3'd0, 16'h0090);
        wait_clk(60);
        wr(3'd0, 16'h009F);
        rd(3'd2, v); check("R8 transfer on match clear", v, 16'h0007);
        rd(3'd1, v); check_true("R8 new period in force", v <= 7, v);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule